// File: doc/BRIEF.md
# I2S Audio Loopback Path

This block is a stereo I2S audio path that runs entirely in the master-clock domain. A clock generator divides MCLK into the bit clock and the word-select clock. A transmitter serialises 24-bit samples onto the DAC data line. A receiver deserialises the ADC data line. The receiver generates no timing of its own. It recovers bit and word boundaries by watching the bit clock and word-select outputs that the transmitter side drives.

The receiver hands each completed word to the transmitter as one stream beat: a ready/valid handshake, 24 data bits and a channel tag bit. Each word therefore plays back one frame after it was captured. The whole path stays in reset while the external clock-lock input is low. When lock rises, reset is released in step with MCLK.

At the default parameters MCLK is 384 times the sample rate (18.432 MHz at 48 kHz). A frame is 64 bit clocks long, so the bit clock is MCLK divided by 6.

Top module: `i2s_loopback_top`

## Requirements
- R1: While `lock_i` is low, `bclk_o`, `lrclk_o`, `dac_sdata_o` and `underflow_o` are all 0, and they clear without waiting for a clock edge. After `lock_i` rises, `bclk_o` first goes high at the fifth MCLK rising edge.
- R2: `bclk_o` has a period of 6 MCLK cycles, with 3 cycles high and 3 cycles low. The divide ratio comes from the parameters: MCLK cycles per frame divided by 64 bit clocks per frame.
- R3: `lrclk_o` changes only at a falling edge of `bclk_o`, and it toggles every 32 bit clocks. Low selects the left channel and high selects the right channel.
- R4: `dac_sdata_o` changes only at a falling edge of `bclk_o`. Within each 32-bit half-frame the bit positions are numbered 0 to 31 from the word-select change. Position 0 is 0, positions 1 to 24 carry the sample MSB first, and positions 25 to 31 are 0.
- R5: The receiver samples `adc_sdata_i` on rising edges of `bclk_o`, and only at positions 1 to 24 of a half-frame. The values at positions 0 and 25 to 31 have no effect. After reset it ignores everything until the first change of `lrclk_o`.
- R6: A word captured in channel c of frame k is sent in channel c of frame k+1, so left and right never swap. The stream keeps data and tag stable while valid is high and ready is low.
- R7: At each half-frame start, the transmitter checks whether a word is stored for that channel. If none is stored, it sends zeros for that half-frame and pulses `underflow_o` high for exactly one MCLK cycle. Frame 0 left sends zeros without a pulse. Every later half-frame start with no word pulses `underflow_o`. After reset this gives exactly two pulses: frame 0 right and frame 1 left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; all logic runs on its rising edge |
| lock_i | input | 1 | Clock-lock indicator; low holds the path in reset |
| adc_sdata_i | input | 1 | Serial audio data from the codec ADC |
| bclk_o | output | 1 | Generated bit clock |
| lrclk_o | output | 1 | Generated word-select clock (0 = left, 1 = right) |
| dac_sdata_o | output | 1 | Serial audio data to the codec DAC |
| underflow_o | output | 1 | One-cycle pulse when a half-frame starts with no stored word |

## Verification
The hardest condition to reach from the ports is the start-up transient. In that window the receiver has discarded the partial first left half, and the transmitter's per-channel stores are still empty. This is the only time underflow can occur and the only time the one-frame alignment is not yet in place. The stimulus reaches it by dropping lock in the middle of a frame and raising it again. The bench then replays the same sample table after the relock and checks the exact underflow count, the first bit-clock edge and every looped word. The bench drives ones into the ignored ADC bit positions, so any receiver capture outside positions 1 to 24 corrupts a checked word.

// File: rtl/i2s_pkg.sv
`timescale 1ns/1ps
package i2s_pkg;
  // stereo: channel tag 0 = left, 1 = right
  localparam int NUM_CH = 2;

  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s_clkgen.sv
`timescale 1ns/1ps
module i2s_clkgen #(
  parameter int MCLK_PER_FS = 384,
  parameter int BITS_PER_CH = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  output logic                           bclk_o,
  output logic                           lrclk_o,
  output logic                           fall_stb_o,
  output logic [$clog2(BITS_PER_CH)-1:0] next_pos_o,
  output logic                           next_chan_o
);
  localparam int BCLK_PER_FS = 2 * BITS_PER_CH;
  localparam int DIV         = MCLK_PER_FS / BCLK_PER_FS;
  localparam int HALF        = DIV / 2;
  localparam int DIV_W       = $clog2(DIV);
  localparam int BIT_W       = $clog2(BCLK_PER_FS);
  localparam int POS_W       = $clog2(BITS_PER_CH);
  localparam logic [DIV_W-1:0] DIV_LAST  = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] HALF_LAST = DIV_W'(HALF - 1);
  localparam logic [DIV_W-1:0] HALF_VAL  = DIV_W'(HALF);

  logic [DIV_W-1:0] div_q, div_n;
  logic [BIT_W-1:0] bit_q, bit_n;
  logic             bclk_q, bclk_n;
  logic             lr_q, lr_n;
  logic             fall_stb;

  assign fall_stb = (div_q == DIV_LAST);

  always_comb begin
    div_n  = fall_stb ? '0 : div_q + 1'b1;
    bclk_n = bclk_q;
    bit_n  = bit_q;
    lr_n   = lr_q;
    if (div_q == HALF_LAST) bclk_n = 1'b1;
    if (fall_stb) begin
      bclk_n = 1'b0;
      bit_n  = bit_q + 1'b1;
      lr_n   = bit_n[BIT_W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      bit_q  <= '0;
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else begin
      div_q  <= div_n;
      bit_q  <= bit_n;
      bclk_q <= bclk_n;
      lr_q   <= lr_n;
    end
  end

  assign bclk_o      = bclk_q;
  assign lrclk_o     = lr_q;
  assign fall_stb_o  = fall_stb;
  assign next_pos_o  = bit_n[POS_W-1:0];
  assign next_chan_o = bit_n[BIT_W-1];

  AST_LR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lr_q) |-> $fell(bclk_q)); // R3
  AST_BCLK_RISE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk_q) |-> (div_q == HALF_VAL)); // R2
endmodule

// File: rtl/i2s_rx_slave.sv
`timescale 1ns/1ps
module i2s_rx_slave #(
  parameter int DATA_W      = 24,
  parameter int BITS_PER_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bclk_i,
  input  logic              lrclk_i,
  input  logic              sdata_i,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [DATA_W-1:0] m_data_o,
  output logic              m_chan_o
);
  localparam int POS_W = $clog2(BITS_PER_CH);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] LAST    = POS_W'(DATA_W);

  logic              bclk_d, lr_prev, lr_prev_n;
  logic [POS_W-1:0]  cnt_q, cnt_n, idx;
  logic [DATA_W-2:0] sreg_q, sreg_n;
  logic              valid_q, valid_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              chan_q, chan_n;
  logic              rise, lr_edge;

  assign rise    = bclk_i && !bclk_d;
  assign lr_edge = (lrclk_i != lr_prev);

  always_comb begin
    idx       = lr_edge ? '0 : ((cnt_q == POS_MAX) ? POS_MAX : cnt_q + 1'b1);
    cnt_n     = cnt_q;
    lr_prev_n = lr_prev;
    sreg_n    = sreg_q;
    valid_n   = valid_q;
    data_n    = data_q;
    chan_n    = chan_q;
    if (valid_q && m_ready_i) valid_n = 1'b0;
    if (rise) begin
      cnt_n     = idx;
      lr_prev_n = lrclk_i;
      if ((idx != '0) && (idx <= LAST)) sreg_n = {sreg_q[DATA_W-3:0], sdata_i};
      if (idx == LAST) begin
        valid_n = 1'b1;
        data_n  = {sreg_q, sdata_i};
        chan_n  = lrclk_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_d  <= 1'b0;
      lr_prev <= 1'b0;
      cnt_q   <= POS_MAX;
      sreg_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      chan_q  <= 1'b0;
    end else begin
      bclk_d  <= bclk_i;
      lr_prev <= lr_prev_n;
      cnt_q   <= cnt_n;
      sreg_q  <= sreg_n;
      valid_q <= valid_n;
      data_q  <= data_n;
      chan_q  <= chan_n;
    end
  end

  assign m_valid_o = valid_q;
  assign m_data_o  = data_q;
  assign m_chan_o  = chan_q;

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !m_ready_i) |=> (valid_q && $stable(data_q) && $stable(chan_q))); // R6
endmodule

// File: rtl/i2s_tx_master.sv
`timescale 1ns/1ps
module i2s_tx_master
  import i2s_pkg::*;
#(
  parameter int DATA_W      = 24,
  parameter int BITS_PER_CH = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fall_stb_i,
  input  logic [$clog2(BITS_PER_CH)-1:0] next_pos_i,
  input  logic                           next_chan_i,
  input  logic                           s_valid_i,
  output logic                           s_ready_o,
  input  logic [DATA_W-1:0]              s_data_i,
  input  logic                           s_chan_i,
  output logic                           sdata_o,
  output logic                           underflow_o
);
  logic              full_vec [NUM_CH];
  logic [DATA_W-1:0] hold_vec [NUM_CH];
  logic              take, load;
  logic [DATA_W-1:0] sreg_q, sreg_n;
  logic              dout_q, dout_n;
  logic              ufl_q, ufl_n;

  assign s_ready_o = !full_vec[s_chan_i];
  assign take      = s_valid_i && s_ready_o;
  assign load      = fall_stb_i && (next_pos_i == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic              full_q, full_n;
    logic [DATA_W-1:0] hold_q, hold_n;

    always_comb begin
      full_n = full_q;
      hold_n = hold_q;
      if (load && (next_chan_i == 1'(c))) full_n = 1'b0;
      if (take && (s_chan_i == 1'(c))) begin
        full_n = 1'b1;
        hold_n = s_data_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        hold_q <= '0;
      end else begin
        full_q <= full_n;
        hold_q <= hold_n;
      end
    end

    assign full_vec[c] = full_q;
    assign hold_vec[c] = hold_q;
  end

  always_comb begin
    sreg_n = sreg_q;
    dout_n = dout_q;
    ufl_n  = 1'b0;
    if (fall_stb_i) begin
      if (load) begin
        sreg_n = full_vec[next_chan_i] ? hold_vec[next_chan_i] : '0;
        dout_n = 1'b0;
        ufl_n  = !full_vec[next_chan_i];
      end else begin
        dout_n = sreg_q[DATA_W-1];
        sreg_n = {sreg_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      dout_q <= 1'b0;
      ufl_q  <= 1'b0;
    end else begin
      sreg_q <= sreg_n;
      dout_q <= dout_n;
      ufl_q  <= ufl_n;
    end
  end

  assign sdata_o     = dout_q;
  assign underflow_o = ufl_q;

  AST_UFL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ufl_q |=> !ufl_q); // R7
  AST_UFL_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ufl_q |-> $past(fall_stb_i)); // R7
endmodule

// File: rtl/i2s_loopback_top.sv
`timescale 1ns/1ps
module i2s_loopback_top #(
  parameter int MCLK_PER_FS = 384,
  parameter int DATA_W      = 24,
  parameter int BITS_PER_CH = 32
) (
  input  logic mclk_i,
  input  logic lock_i,
  input  logic adc_sdata_i,
  output logic bclk_o,
  output logic lrclk_o,
  output logic dac_sdata_o,
  output logic underflow_o
);
  localparam int POS_W = $clog2(BITS_PER_CH);

  logic [1:0]        lock_sync;
  logic              rst_n;
  logic              fall_stb, next_chan;
  logic [POS_W-1:0]  next_pos;
  logic              st_valid, st_ready, st_chan;
  logic [DATA_W-1:0] st_data;

  // reset asserts at once when lock drops, releases after two MCLK edges
  always_ff @(posedge mclk_i or negedge lock_i) begin
    if (!lock_i) lock_sync <= 2'b00;
    else         lock_sync <= {lock_sync[0], 1'b1};
  end
  assign rst_n = lock_sync[1];

  i2s_clkgen #(
    .MCLK_PER_FS(MCLK_PER_FS),
    .BITS_PER_CH(BITS_PER_CH)
  ) u_clkgen (
    .clk        (mclk_i),
    .rst_n      (rst_n),
    .bclk_o     (bclk_o),
    .lrclk_o    (lrclk_o),
    .fall_stb_o (fall_stb),
    .next_pos_o (next_pos),
    .next_chan_o(next_chan)
  );

  i2s_rx_slave #(
    .DATA_W     (DATA_W),
    .BITS_PER_CH(BITS_PER_CH)
  ) u_rx (
    .clk      (mclk_i),
    .rst_n    (rst_n),
    .bclk_i   (bclk_o),
    .lrclk_i  (lrclk_o),
    .sdata_i  (adc_sdata_i),
    .m_valid_o(st_valid),
    .m_ready_i(st_ready),
    .m_data_o (st_data),
    .m_chan_o (st_chan)
  );

  i2s_tx_master #(
    .DATA_W     (DATA_W),
    .BITS_PER_CH(BITS_PER_CH)
  ) u_tx (
    .clk        (mclk_i),
    .rst_n      (rst_n),
    .fall_stb_i (fall_stb),
    .next_pos_i (next_pos),
    .next_chan_i(next_chan),
    .s_valid_i  (st_valid),
    .s_ready_o  (st_ready),
    .s_data_i   (st_data),
    .s_chan_i   (st_chan),
    .sdata_o    (dac_sdata_o),
    .underflow_o(underflow_o)
  );

  always_ff @(posedge mclk_i) begin
    if (!rst_n) begin
      AST_IDLE_IN_RESET: assert (!bclk_o && !lrclk_o && !dac_sdata_o && !underflow_o); // R1
    end
  end

  AST_DAC_ON_FALL: assert property (@(posedge mclk_i) disable iff (!rst_n)
    !$stable(dac_sdata_o) |-> $fell(bclk_o)); // R4
endmodule

// File: tb/i2s_loopback_top_tb_top.sv
`timescale 1ns/1ps
module i2s_loopback_top_tb_top;
  localparam int NV  = 8;
  localparam int DW  = 24;
  localparam int HALF_DIV = 3;
  localparam logic [DW-1:0] VEC_L [NV] = '{24'hFFFFFF, 24'h800000, 24'h000001, 24'hA5A5A5,
                                           24'h123456, 24'h7FFFFF, 24'h000000, 24'hC3C3C3};
  localparam logic [DW-1:0] VEC_R [NV] = '{24'h000000, 24'h7FFFFF, 24'h800001, 24'h5A5A5A,
                                           24'hFEDCBA, 24'h000001, 24'hFFFFFF, 24'h3C3C3C};

  logic clk = 1'b0;
  logic lock, adc;
  logic bclk, lrclk, dac, ufl;

  always #2 clk = ~clk;

  i2s_loopback_top dut_i (
    .mclk_i     (clk),
    .lock_i     (lock),
    .adc_sdata_i(adc),
    .bclk_o     (bclk),
    .lrclk_o    (lrclk),
    .dac_sdata_o(dac),
    .underflow_o(ufl)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  bit mon_en = 0;
  int mon_pos, mon_frame, drv_pos, drv_frame;
  logic mon_lr, drv_lr;
  logic [DW-1:0] cap;
  bit pad_err, first_edge;
  int run, duty_err, lr_err, dac_err, ufl_cnt;
  logic pb, pl, pd;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] in_word(input int f, input logic c);
    if (f < 0 || f >= NV) return '0;
    return c ? VEC_R[f] : VEC_L[f];
  endfunction

  // one-frame loopback: frame 0 and frame 1 left carry zeros
  function automatic logic [DW-1:0] exp_word(input int f, input logic c);
    if (f == 0 || (f == 1 && c == 1'b0)) return '0;
    return in_word(f - 1, c);
  endfunction

  // ADC driver and DAC monitor, acting away from the active edge
  initial begin
    pb = 0; pl = 0; pd = 0;
    forever begin
      @(negedge clk);
      if (mon_en) begin
        if (bclk != pb) begin
          if (!first_edge && run != HALF_DIV) duty_err++;
          first_edge = 0;
          run = 1;
        end else run++;
        if (lrclk != pl && !(pb && !bclk)) lr_err++;
        if (dac != pd && !(pb && !bclk)) dac_err++;
        if (ufl) ufl_cnt++;
        if (pb && !bclk) begin
          if (lrclk != drv_lr) begin
            drv_pos = 0;
            if (!lrclk) drv_frame++;
            drv_lr = lrclk;
          end else drv_pos++;
          // positions outside 1..24 get ones, which must be ignored (R5)
          if (drv_pos >= 1 && drv_pos <= DW) begin
            logic [DW-1:0] w;
            w = in_word(drv_frame, lrclk);
            adc = w[DW - drv_pos];
          end else adc = 1'b1;
        end
        if (!pb && bclk) begin
          if (lrclk != mon_lr) begin
            if (mon_pos != 31) lr_err++;
            mon_pos = 0;
            if (!lrclk) mon_frame++;
            mon_lr = lrclk;
          end else mon_pos++;
          if (mon_pos >= 1 && mon_pos <= DW) cap = {cap[DW-2:0], dac};
          else if (dac) pad_err = 1;
          if (mon_pos == 31) begin
            chk(cap == exp_word(mon_frame, lrclk), "R5 R6 looped word",
                {7'd0, lrclk, cap}, {7'd0, lrclk, exp_word(mon_frame, lrclk)});
            chk(!pad_err, "R4 zero padding", {31'd0, pad_err}, 32'd0);
            cap = '0;
            pad_err = 0;
          end
        end
      end
      pb = bclk; pl = lrclk; pd = dac;
    end
  end

  task automatic run_pass();
    @(negedge clk);
    #1;
    mon_pos = -1; mon_frame = 0; mon_lr = 0;
    drv_pos = 0;  drv_frame = 0; drv_lr = 0;
    cap = '0; pad_err = 0; first_edge = 1; run = 0;
    duty_err = 0; lr_err = 0; dac_err = 0; ufl_cnt = 0;
    adc = 1'b1;
    mon_en = 1;
    lock = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      if (k == 4) chk(bclk == 1'b0, "R1 bclk still low", {31'd0, bclk}, 32'd0);
      if (k == 5) chk(bclk == 1'b1, "R1 first bclk rise", {31'd0, bclk}, 32'd1);
    end
    while (mon_frame < NV + 2) @(negedge clk);
    chk(duty_err == 0, "R2 bclk 3 high 3 low", duty_err, 0);
    chk(lr_err == 0, "R3 lrclk timing", lr_err, 0);
    chk(dac_err == 0, "R4 dac on falling bclk", dac_err, 0);
    chk(ufl_cnt == 2, "R7 underflow pulses", ufl_cnt, 2);
    @(negedge clk);
    #1;
    lock = 1'b0;
    #1;
    chk({bclk, lrclk, dac, ufl} == 4'b0000, "R1 async idle on lock loss", {28'd0, bclk, lrclk, dac, ufl}, 0);
    mon_en = 0;
  endtask

  initial begin
    lock = 1'b1;
    adc  = 1'b1;
    #1 lock = 1'b0;
    repeat (3) @(negedge clk);
    chk({bclk, lrclk, dac, ufl} == 4'b0000, "R1 reset state", {28'd0, bclk, lrclk, dac, ufl}, 0);
    repeat (4) @(negedge clk);
    chk({bclk, lrclk, dac, ufl} == 4'b0000, "R1 held while unlocked", {28'd0, bclk, lrclk, dac, ufl}, 0);
    run_pass();
    repeat (10) @(negedge clk);
    run_pass();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL R6 watchdog expired actual=%0d expected=%0d", mon_frame, NV + 2);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule